// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

The block holds a small set of recently used virtual-to-physical page mappings. Any slot can hold any mapping. Each slot is tagged with an address-space identifier, or marked global so that it serves every address space, and it carries a set of access-right bits. A lookup compares the virtual page number and the current identifier against every slot in parallel. On a hit, the block returns the physical address, formed from the cached frame number and the untranslated page offset. In the same cycle it reports whether the requested kind of access is permitted.

On a miss, an external page-walk agent fetches the mapping and presents it on the refill port. The block then stores it in a free slot if one exists. If every slot is occupied, it evicts a slot chosen by a free-running pseudo-random generator. A refill that collides with mappings already present replaces them, so no page is cached twice. Software can discard every mapping at once, or only the non-global mappings of one address space.

Top module: `tlb_asid`

## Requirements
- R1: After reset every slot is empty, so every lookup misses.
- R2: A lookup hits when a valid slot holds the same virtual page number (address bits 31:12) and matches the address space. On a hit the physical address is the slot's frame number in bits 31:12 and the lookup's page offset (bits 11:0) unchanged.
- R3: A non-global slot matches only its own identifier. A global slot matches any identifier.
- R4: The miss output is high only when a lookup is requested and no slot matches. With no request, hit and miss are both low. The physical address reads zero whenever there is no hit.
- R5: Permission bits: bit 0 read, bit 1 write, bit 2 execute, bit 3 user. Access code 00 is read, 01 is write, 10 is execute, and 11 always faults. The fault output rises with a hit when the needed bit is clear, or when a user-mode access meets a slot with bit 3 clear. The hit output and the physical address are still given.
- R6: While any slot is empty, a refill never evicts a valid mapping.
- R7: When every slot is full, a refill of a new page evicts exactly one existing mapping, and the new mapping hits.
- R8: A refill whose page matches existing slots replaces them. The page then matches a single slot that carries the new frame and rights, and no unrelated mapping is lost. A global refill covers every identifier.
- R9: Flush-all leaves every slot empty from the next cycle. A refill offered in the same cycle is dropped.
- R10: Flush by identifier empties only the non-global slots that carry that identifier. A refill offered in the same cycle is dropped.
- R11: A lookup answers in the cycle it is presented. A refill becomes visible from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Current address-space identifier |
| lk_acc_i | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| lk_user_i | input | 1 | Access made in user mode |
| lk_hit_o | output | 1 | Lookup matched a slot |
| lk_miss_o | output | 1 | Lookup requested and nothing matched |
| lk_fault_o | output | 1 | Hit but access not permitted |
| lk_paddr_o | output | 32 | Translated physical address, zero without a hit |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Virtual page number to insert |
| fill_asid_i | input | 8 | Identifier of the new mapping |
| fill_pfn_i | input | 20 | Physical frame number of the new mapping |
| fill_perm_i | input | 4 | Rights of the new mapping |
| fill_global_i | input | 1 | New mapping serves every identifier |
| flush_all_i | input | 1 | Empty every slot |
| flush_asid_i | input | 1 | Empty the non-global slots of one identifier |
| flush_asid_id_i | input | 8 | Identifier for the selective flush |

## Verification
The assertions assume a power-of-two slot count and inputs that are known after reset. The stimulus holds every input at a defined value from time zero, and changes inputs only at the falling edge. The check that each lookup matches at most one slot relies on every slot having been written through the refill port, which removes colliding entries. No slot is loaded any other way. The stimulus includes a global refill over two same-page, different-identifier entries, to exercise the collapse onto a single slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W   = 4;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;
  localparam int PERM_USR = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // maximal-length Galois feedback masks
  function automatic logic [15:0] lfsr_taps(input int width);
    case (width)
      3:       lfsr_taps = 16'h0006;
      4:       lfsr_taps = 16'h000C;
      5:       lfsr_taps = 16'h0014;
      6:       lfsr_taps = 16'h0030;
      7:       lfsr_taps = 16'h0060;
      8:       lfsr_taps = 16'h00B8;
      default: lfsr_taps = 16'h0014;
    endcase
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] TAPS = W'(tlb_pkg::lfsr_taps(W));

  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= W'(1);
    else         state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  assign state_o = state_q;
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0]             glob_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]               key_vpn_i,
  input  logic [ASID_W-1:0]              key_asid_i,
  input  logic                           any_asid_i,
  output logic [ENTRIES-1:0]             match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) &&
                        (glob_i[g] || any_asid_i || (asid_i[g] == key_asid_i));
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest set index wins
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |req_i;
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int PERM_W = tlb_pkg::PERM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [1:0]        lk_acc_i,
  input  logic              lk_user_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              fill_global_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i
);
  import tlb_pkg::*;

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int LFSR_W = IDX_W + 1;

  logic [ENTRIES-1:0]              valid_q, glob_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0]  perm_q;

  logic [ENTRIES-1:0] lk_vec, fl_vec, asid_kill, victim_oh;
  logic [VPN_W-1:0]   lk_vpn;
  logic [PFN_W-1:0]   hit_pfn;
  logic [PERM_W-1:0]  hit_perm;
  logic               any_hit, need_ok, allowed;
  logic               dup_found, free_found, fill_go;
  logic [IDX_W-1:0]   dup_idx, free_idx, victim;
  logic [LFSR_W-1:0]  rnd;
  acc_e               acc;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFF_W];
  assign acc    = acc_e'(lk_acc_i);

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid_i(valid_q), .glob_i(glob_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lk_vpn), .key_asid_i(lk_asid_i), .any_asid_i(1'b0),
    .match_o(lk_vec)
  );

  // a global refill collides with every slot of the same page
  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
    .valid_i(valid_q), .glob_i(glob_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i), .any_asid_i(fill_global_i),
    .match_o(fl_vec)
  );

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick_dup (
    .req_i(fl_vec), .found_o(dup_found), .idx_o(dup_idx)
  );

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick_free (
    .req_i(~valid_q), .found_o(free_found), .idx_o(free_idx)
  );

  tlb_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_o(rnd)
  );

  // ---------------- lookup ----------------
  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) begin
        hit_pfn  = hit_pfn  | pfn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
    end
  end

  always_comb begin
    unique case (acc)
      ACC_READ:  need_ok = hit_perm[PERM_RD];
      ACC_WRITE: need_ok = hit_perm[PERM_WR];
      ACC_EXEC:  need_ok = hit_perm[PERM_EX];
      default:   need_ok = 1'b0;
    endcase
    allowed = need_ok && (!lk_user_i || hit_perm[PERM_USR]);
  end

  assign any_hit    = |lk_vec;
  assign lk_hit_o   = lk_valid_i && any_hit;
  assign lk_miss_o  = lk_valid_i && !any_hit;
  assign lk_fault_o = lk_hit_o && !allowed;
  assign lk_paddr_o = lk_hit_o ? {hit_pfn, lk_vaddr_i[OFF_W-1:0]} : '0;

  // ---------------- refill / flush ----------------
  assign fill_go   = fill_valid_i && !flush_all_i && !flush_asid_i;
  assign victim    = dup_found  ? dup_idx  :
                     free_found ? free_idx : rnd[IDX_W-1:0];
  assign victim_oh = {{(ENTRIES-1){1'b0}}, 1'b1} << victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
    assign asid_kill[g] = !glob_q[g] && (asid_q[g] == flush_asid_id_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else if (flush_all_i) begin
      valid_q <= '0;
    end else if (flush_asid_i) begin
      valid_q <= valid_q & ~asid_kill;
    end else if (fill_go) begin
      valid_q        <= (valid_q & ~fl_vec) | victim_oh;
      glob_q[victim] <= fill_global_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_go) begin
      vpn_q[victim]  <= fill_vpn_i;
      asid_q[victim] <= fill_asid_i;
      pfn_q[victim]  <= fill_pfn_i;
      perm_q[victim] <= fill_perm_i;
    end
  end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic [VA_W-1:0]    lk_vaddr_i,
  input logic               lk_hit_o,
  input logic               lk_miss_o,
  input logic               lk_fault_o,
  input logic [PA_W-1:0]    lk_paddr_o,
  input logic               fill_valid_i,
  input logic               flush_all_i,
  input logic               flush_asid_i,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lk_vec
);
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec)); // R8
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o)); // R4
  AST_MISS_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> lk_valid_i); // R4
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o); // R5
  AST_OFFSET_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0])); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0)); // R9
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_all_i && !flush_asid_i) |=> (valid_q != '0)); // R6
  AST_ASID_FLUSH_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_asid_i && !flush_all_i) |=> ($countones(valid_q) <= $countones($past(valid_q)))); // R10
endmodule

bind tlb_asid tlb_asid_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i),
  .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_fault_o(lk_fault_o),
  .lk_paddr_o(lk_paddr_o), .fill_valid_i(fill_valid_i), .flush_all_i(flush_all_i),
  .flush_asid_i(flush_asid_i), .valid_q(valid_q), .lk_vec(lk_vec)
);

// File: tb/tlb_asid_tb_top.sv
module tlb_asid_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic [3:0]  fill_perm = '0;
  logic        fill_global = 1'b0;
  logic        flush_all = 1'b0;
  logic        flush_asid = 1'b0;
  logic [7:0]  flush_id = '0;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic        hit;
    logic        miss;
    logic        fault;
    logic [31:0] pa;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  tlb_asid dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid),
    .lk_acc_i(lk_acc), .lk_user_i(lk_user),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault), .lk_paddr_o(lk_paddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm), .fill_global_i(fill_global),
    .flush_all_i(flush_all), .flush_asid_i(flush_asid), .flush_asid_id_i(flush_id)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(lk_hit == e.hit,     e.tag, "hit",   lk_hit,   e.hit);
        chk(lk_miss == e.miss,   e.tag, "miss",  lk_miss,  e.miss);
        chk(lk_fault == e.fault, e.tag, "fault", lk_fault, e.fault);
        chk(lk_paddr == e.pa,    e.tag, "paddr", lk_paddr, e.pa);
      end
    end
  end

  function automatic exp_t mk(input bit v, input bit h, input bit f,
                              input logic [19:0] pfn, input logic [11:0] off, input string tag);
    exp_t e;
    e.hit   = v && h;
    e.miss  = v && !h;
    e.fault = v && h && f;
    e.pa    = (v && h) ? {pfn, off} : 32'h0;
    e.tag   = tag;
    return e;
  endfunction

  task automatic look(input bit v, input logic [19:0] vpn, input logic [7:0] asid,
                      input logic [11:0] off, input logic [1:0] acc, input bit user,
                      input bit e_hit, input bit e_fault, input logic [19:0] e_pfn,
                      input string tag);
    @(negedge clk);
    fill_valid = 1'b0; flush_all = 1'b0; flush_asid = 1'b0;
    lk_valid = v; lk_vaddr = {vpn, off}; lk_asid = asid; lk_acc = acc; lk_user = user;
    sb.push_back(mk(v, e_hit, e_fault, e_pfn, off, tag));
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                      input logic [3:0] perm, input bit glob);
    @(negedge clk);
    lk_valid = 1'b0;
    fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
    fill_perm = perm; fill_global = glob;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush(input bit all, input bit by_id, input logic [7:0] id, input bit with_fill);
    @(negedge clk);
    lk_valid = 1'b0;
    flush_all = all; flush_asid = by_id; flush_id = id;
    fill_valid = with_fill; fill_vpn = 20'h0BEEF; fill_asid = id;
    fill_pfn = 20'h0CAFE; fill_perm = 4'hF; fill_global = 1'b0;
    @(negedge clk);
    flush_all = 1'b0; flush_asid = 1'b0; fill_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    #3 chk(lk_hit == 1'b0 && lk_miss == 1'b0, "R1", "idle outputs", {lk_hit, lk_miss}, 0);
    look(1, 20'h00005, 8'd1, 12'h000, 2'b00, 0, 0, 0, 0, "R1");
    look(1, 20'h00000, 8'd0, 12'h000, 2'b00, 0, 0, 0, 0, "R1");

    // R11: lookup same cycle as refill sees old state, then new
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {20'h12345, 12'h7FF}; lk_asid = 8'd3; lk_acc = 2'b00; lk_user = 1'b0;
    fill_valid = 1'b1; fill_vpn = 20'h12345; fill_asid = 8'd3; fill_pfn = 20'hABCDE;
    fill_perm = 4'b0011; fill_global = 1'b0;
    sb.push_back(mk(1, 0, 0, 0, 12'h7FF, "R11"));
    @(negedge clk);
    fill_valid = 1'b0;
    sb.push_back(mk(1, 1, 0, 20'hABCDE, 12'h7FF, "R11"));

    // R2 / R3 / R4
    look(1, 20'h12345, 8'd3, 12'h123, 2'b01, 0, 1, 0, 20'hABCDE, "R2");
    look(1, 20'h12345, 8'd4, 12'h123, 2'b00, 0, 0, 0, 0, "R3");
    look(1, 20'h12346, 8'd3, 12'h123, 2'b00, 0, 0, 0, 0, "R2");
    look(0, 20'h12345, 8'd3, 12'h123, 2'b00, 0, 0, 0, 0, "R4");

    // R5: permissions on rights R/W, kernel only
    look(1, 20'h12345, 8'd3, 12'h010, 2'b10, 0, 1, 1, 20'hABCDE, "R5");
    look(1, 20'h12345, 8'd3, 12'h010, 2'b00, 1, 1, 1, 20'hABCDE, "R5");
    look(1, 20'h12345, 8'd3, 12'h010, 2'b11, 0, 1, 1, 20'hABCDE, "R5");

    // global mapping: R, X, U
    fill(20'h00042, 8'd9, 20'h00777, 4'b1101, 1);
    look(1, 20'h00042, 8'd200, 12'hFFF, 2'b10, 1, 1, 0, 20'h00777, "R3");
    look(1, 20'h00042, 8'd0, 12'h001, 2'b01, 1, 1, 1, 20'h00777, "R5");

    // R10: flush asid 3, fill in same cycle dropped (fill asid = 3, vpn 0BEEF)
    do_flush(0, 1, 8'd3, 1);
    look(1, 20'h12345, 8'd3, 12'h000, 2'b00, 0, 0, 0, 0, "R10");
    look(1, 20'h0BEEF, 8'd3, 12'h000, 2'b00, 0, 0, 0, 0, "R10");
    look(1, 20'h00042, 8'd3, 12'h000, 2'b00, 0, 1, 0, 20'h00777, "R10");

    // R9: flush all with same-cycle fill
    do_flush(1, 0, 8'd7, 1);
    look(1, 20'h00042, 8'd3, 12'h000, 2'b00, 0, 0, 0, 0, "R9");
    look(1, 20'h0BEEF, 8'd7, 12'h000, 2'b00, 0, 0, 0, 0, "R9");

    // R6: fill every slot, nothing lost
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 8'd1, 20'h00200 + 20'(i), 4'b0001, 0);
    for (int i = 0; i < N; i++)
      look(1, 20'h00100 + 20'(i), 8'd1, 12'h0AB, 2'b00, 0, 1, 0, 20'h00200 + 20'(i), "R6");

    // R8: overwrite existing page while full, no eviction
    fill(20'h00105, 8'd1, 20'h00999, 4'b0010, 0);
    for (int i = 0; i < N; i++)
      look(1, 20'h00100 + 20'(i), 8'd1, 12'h0AB, 2'b00, 0, 1, (i == 5),
           (i == 5) ? 20'h00999 : 20'h00200 + 20'(i), "R8");

    // R7: new page while full evicts exactly one
    fill(20'h00300, 8'd1, 20'h00333, 4'b0001, 0);
    look(1, 20'h00300, 8'd1, 12'h000, 2'b00, 0, 1, 0, 20'h00333, "R7");
    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
    hits = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = {20'h00100 + 20'(i), 12'h0}; lk_asid = 8'd1; lk_acc = 2'b00;
      #3 if (lk_hit) hits++;
    end
    chk(hits == N - 1, "R7", "surviving mappings", hits, N - 1);

    // R8: global refill collapses same-page entries of two spaces
    do_flush(1, 0, 8'd0, 0);
    fill(20'h00050, 8'd1, 20'h00011, 4'b0001, 0);
    fill(20'h00050, 8'd2, 20'h00022, 4'b0001, 0);
    fill(20'h00060, 8'd2, 20'h00066, 4'b0001, 0);
    look(1, 20'h00050, 8'd2, 12'h004, 2'b00, 0, 1, 0, 20'h00022, "R8");
    fill(20'h00050, 8'd5, 20'h00077, 4'b0001, 1);
    look(1, 20'h00050, 8'd1, 12'h004, 2'b00, 0, 1, 0, 20'h00077, "R8");
    look(1, 20'h00050, 8'd2, 12'h004, 2'b00, 0, 1, 0, 20'h00077, "R8");
    look(1, 20'h00050, 8'd3, 12'h004, 2'b00, 0, 1, 0, 20'h00077, "R8");
    look(1, 20'h00060, 8'd2, 12'h004, 2'b00, 0, 1, 0, 20'h00066, "R8");

    @(negedge clk);
    lk_valid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule